// File: doc/BRIEF.md
# I2C SCL Timing and Line Filter Generator

This block produces the serial clock of an I2C controller and conditions both bus lines for the byte engine that sits above it. It drives SCL low and releases it using per-mode cycle counts. A 2-bit speed selector picks one of three independent high/low count pairs: standard, fast and high-speed. Both incoming lines pass through a synchronizer and a programmable spike filter. The high phase is timed from the moment the filtered SCL is seen high. A target that holds SCL low after release therefore lengthens the low phase. This is reported as a stretch.

For the byte engine, the block marks the first cycle of every SCL low phase. After a programmable transmit hold count it gives a one-cycle strobe and moves its registered SDA output to the bit the engine presents. It also gives a one-cycle sample strobe a programmable receive hold count into the high phase. Clocks run while `runEn` is high. When `runEn` drops, the block finishes the high phase in progress and leaves SCL released.

Top module: `i2c_scl_timing`

## Requirements
- R1: While reset is held and directly after it: `sclOut`=1, `sdaOut`=1, `sclFilt`=1, `sdaFilt`=1, and `fallStb`, `sdaChgStb`, `sampleStb` and `stretchDet` are all 0.
- R2: `speedMode` selects the active count pair: 0 selects standard, 1 selects fast, 2 selects high-speed, and the reserved value 3 falls back to the standard pair.
- R3: `sclOut` stays low for exactly (active low count + 1) cycles.
- R4: When the bus follows `sclOut`, SCL stays high for exactly (active high count + `spikeLen` + 7) cycles, from the rise of the line to the next pull-low. This holds for any `SYNC_STAGES` from 1 to 4. The active low count must exceed `SYNC_STAGES`+`spikeLen`.
- R5: If SCL is held low after release, the high count does not start until the filtered line is high. The full R4 high time follows the line's rise. `stretchDet` is 1 only while SCL is released and the line has not yet risen, past the `SYNC_STAGES`+1+`spikeLen` cycles a following bus needs. `stretchDet` never rises on an unstretched bus.
- R6: A level on SCL or SDA that differs from the filtered value for `spikeLen` cycles or fewer is ignored. A level held `spikeLen`+1 cycles or longer reaches the filtered output `SYNC_STAGES`+1+`spikeLen` cycles after it first appears on the pin.
- R7: `sdaChgStb` pulses for one cycle, `txHold` cycles after the first low cycle of SCL. `sdaOut` takes `sdaTxBit` at the end of that cycle and changes at no other time.
- R8: `sampleStb` pulses for one cycle. The pulse comes `SYNC_STAGES`+2+`spikeLen`+`rxHold` cycles after SCL rises.
- R9: After `runEn` falls, the high phase in progress ends and `sclOut` stays 1 with no further `fallStb`.
- R10: `fallStb` is 1 in exactly the first cycle of each SCL low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Keep generating SCL periods while high |
| speedMode | input | 2 | Active count pair: 0 standard, 1 fast, 2 high-speed, 3 standard |
| stdHi | input | CNT_W | Standard-mode high count |
| stdLo | input | CNT_W | Standard-mode low count |
| fastHi | input | CNT_W | Fast-mode high count |
| fastLo | input | CNT_W | Fast-mode low count |
| hsHi | input | CNT_W | High-speed-mode high count |
| hsLo | input | CNT_W | High-speed-mode low count |
| spikeLen | input | SPK_W | Spike filter length in cycles |
| txHold | input | TXH_W | Cycles from SCL fall to the SDA change strobe |
| rxHold | input | RXH_W | Cycles into the high phase for the sample strobe |
| sclIn | input | 1 | SCL line as seen on the bus |
| sdaIn | input | 1 | SDA line as seen on the bus |
| sdaTxBit | input | 1 | Next SDA level from the byte engine |
| sclOut | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sdaOut | output | 1 | SDA drive, updated after the hold time |
| sclFilt | output | 1 | Filtered SCL |
| sdaFilt | output | 1 | Filtered SDA |
| fallStb | output | 1 | First cycle of an SCL low phase |
| sdaChgStb | output | 1 | Transmit hold elapsed |
| sampleStb | output | 1 | Receive sample point |
| stretchDet | output | 1 | SCL held low by another device after release |

## Verification
The bench builds the block with `CNT_W`=12 and `SYNC_STAGES`=3 instead of the default 2. With the deeper synchronizer, the fixed 7-cycle high overhead and the filter latency are checked at a non-default depth. Small counts and spike lengths of 0, 2 and 4 keep each SCL period under thirty cycles. Whole periods in every mode can then be measured cycle by cycle. The hold and sample strobes fall at exact indices well inside their phases. The same spike settings reach both the pass and the reject edge of the filter.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_WAIT = 2'd2,
    PH_HIGH = 2'd3
  } phase_e;

  // strobes from the phase control into the datapath
  typedef struct packed {
    logic ldLow;   // SCL is pulled low this edge
    logic ldWait;  // SCL is released this edge
    logic ldHigh;  // filtered SCL seen high, high count starts
  } phase_stb_t;

  localparam logic [1:0] MODE_STD  = 2'd0;
  localparam logic [1:0] MODE_FAST = 2'd1;
  localparam logic [1:0] MODE_HS   = 2'd2;

endpackage

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int LEN_W       = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LEN_W-1:0] filtLen,
  input  logic             lineIn,
  output logic             lineFilt
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;
  logic [LEN_W-1:0]       stableCnt;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= lineIn;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  // a differing level must survive filtLen+1 samples before it is taken
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineFilt  <= 1'b1;
      stableCnt <= '0;
    end else if (syncOut == lineFilt) begin
      stableCnt <= '0;
    end else if (stableCnt >= filtLen) begin
      lineFilt  <= syncOut;
      stableCnt <= '0;
    end else begin
      stableCnt <= stableCnt + LEN_W'(1);
    end
  end

endmodule

// File: rtl/scl_timing_ctrl.sv
module scl_timing_ctrl
  import scl_timing_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic       sclFilt,
  input  logic       cntZero,
  output phase_stb_t stb,
  output logic       sclOut,
  output logic       fallStb,
  output logic       stretchDet
);

  phase_e phase;

  always_comb begin
    stb        = '0;
    stb.ldLow  = runEn && ((phase == PH_IDLE) || (phase == PH_HIGH && cntZero));
    stb.ldWait = (phase == PH_LOW) && cntZero;
    stb.ldHigh = (phase == PH_WAIT) && sclFilt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      sclOut  <= 1'b1;
      fallStb <= 1'b0;
    end else begin
      fallStb <= stb.ldLow;
      if (stb.ldLow) begin
        phase  <= PH_LOW;
        sclOut <= 1'b0;
      end else if (stb.ldWait) begin
        phase  <= PH_WAIT;
        sclOut <= 1'b1;
      end else if (stb.ldHigh) begin
        phase <= PH_HIGH;
      end else if (phase == PH_HIGH && cntZero) begin
        phase <= PH_IDLE;
      end
    end
  end

  // the wait counter runs out exactly when a following bus would be seen high
  assign stretchDet = (phase == PH_WAIT) && cntZero && !sclFilt;

endmodule

// File: rtl/scl_timing_dp.sv
module scl_timing_dp
  import scl_timing_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SPK_W       = 8,
  parameter int TXH_W       = 16,
  parameter int RXH_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  phase_stb_t       stb,
  input  logic [1:0]       speedMode,
  input  logic [CNT_W-1:0] stdHi,
  input  logic [CNT_W-1:0] stdLo,
  input  logic [CNT_W-1:0] fastHi,
  input  logic [CNT_W-1:0] fastLo,
  input  logic [CNT_W-1:0] hsHi,
  input  logic [CNT_W-1:0] hsLo,
  input  logic [SPK_W-1:0] spikeLen,
  input  logic [TXH_W-1:0] txHold,
  input  logic [RXH_W-1:0] rxHold,
  input  logic             sdaTxBit,
  output logic             cntZero,
  output logic             sdaOut,
  output logic             sdaChgStb,
  output logic             sampleStb
);

  localparam int CW     = CNT_W + 1;
  // release to filtered-high costs SYNC_STAGES+2+spikeLen edges; the rest of 7 is counted here
  localparam int HI_OFF = 4 - SYNC_STAGES;
  localparam int WAIT_BASE = SYNC_STAGES + 1;

  logic [CNT_W-1:0] hiSel;
  logic [CNT_W-1:0] loSel;
  logic [CW-1:0]    phaseCnt;
  logic [TXH_W-1:0] txCnt;
  logic             txAct;
  logic [RXH_W-1:0] rxCnt;
  logic             rxAct;

  always_comb begin
    case (speedMode)
      MODE_FAST: begin hiSel = fastHi; loSel = fastLo; end
      MODE_HS:   begin hiSel = hsHi;   loSel = hsLo;   end
      default:   begin hiSel = stdHi;  loSel = stdLo;  end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt <= '0;
    end else if (stb.ldLow) begin
      phaseCnt <= CW'(loSel);
    end else if (stb.ldWait) begin
      phaseCnt <= CW'(WAIT_BASE) + CW'(spikeLen);
    end else if (stb.ldHigh) begin
      phaseCnt <= CW'(hiSel) + CW'(HI_OFF);
    end else if (phaseCnt != '0) begin
      phaseCnt <= phaseCnt - CW'(1);
    end
  end

  assign cntZero = (phaseCnt == '0);

  // transmit hold: counts from the SCL fall, then moves SDA
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txAct  <= 1'b0;
      txCnt  <= '0;
      sdaOut <= 1'b1;
    end else if (stb.ldLow) begin
      txAct <= 1'b1;
      txCnt <= txHold;
    end else if (txAct) begin
      if (txCnt == '0) begin
        txAct  <= 1'b0;
        sdaOut <= sdaTxBit;
      end else begin
        txCnt <= txCnt - TXH_W'(1);
      end
    end
  end

  assign sdaChgStb = txAct && (txCnt == '0);

  // receive sample point: counts from the start of the high count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxAct <= 1'b0;
      rxCnt <= '0;
    end else if (stb.ldHigh) begin
      rxAct <= 1'b1;
      rxCnt <= rxHold;
    end else if (rxAct) begin
      if (rxCnt == '0) rxAct <= 1'b0;
      else             rxCnt <= rxCnt - RXH_W'(1);
    end
  end

  assign sampleStb = rxAct && (rxCnt == '0);

endmodule

// File: rtl/i2c_scl_timing.sv
module i2c_scl_timing
  import scl_timing_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SPK_W       = 8,
  parameter int TXH_W       = 16,
  parameter int RXH_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic [1:0]       speedMode,
  input  logic [CNT_W-1:0] stdHi,
  input  logic [CNT_W-1:0] stdLo,
  input  logic [CNT_W-1:0] fastHi,
  input  logic [CNT_W-1:0] fastLo,
  input  logic [CNT_W-1:0] hsHi,
  input  logic [CNT_W-1:0] hsLo,
  input  logic [SPK_W-1:0] spikeLen,
  input  logic [TXH_W-1:0] txHold,
  input  logic [RXH_W-1:0] rxHold,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic             sdaTxBit,
  output logic             sclOut,
  output logic             sdaOut,
  output logic             sclFilt,
  output logic             sdaFilt,
  output logic             fallStb,
  output logic             sdaChgStb,
  output logic             sampleStb,
  output logic             stretchDet
);

  localparam int NUM_LINES = 2;

  logic [NUM_LINES-1:0] rawLines;
  logic [NUM_LINES-1:0] filtLines;
  phase_stb_t           stb;
  logic                 cntZero;

  assign rawLines = {sdaIn, sclIn};

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_filt
    scl_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .LEN_W      (SPK_W)
    ) u_filt (
      .clk     (clk),
      .rstN    (rstN),
      .filtLen (spikeLen),
      .lineIn  (rawLines[i]),
      .lineFilt(filtLines[i])
    );
  end

  assign sclFilt = filtLines[0];
  assign sdaFilt = filtLines[1];

  scl_timing_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .sclFilt   (sclFilt),
    .cntZero   (cntZero),
    .stb       (stb),
    .sclOut    (sclOut),
    .fallStb   (fallStb),
    .stretchDet(stretchDet)
  );

  scl_timing_dp #(
    .CNT_W      (CNT_W),
    .SPK_W      (SPK_W),
    .TXH_W      (TXH_W),
    .RXH_W      (RXH_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .speedMode(speedMode),
    .stdHi    (stdHi),
    .stdLo    (stdLo),
    .fastHi   (fastHi),
    .fastLo   (fastLo),
    .hsHi     (hsHi),
    .hsLo     (hsLo),
    .spikeLen (spikeLen),
    .txHold   (txHold),
    .rxHold   (rxHold),
    .sdaTxBit (sdaTxBit),
    .cntZero  (cntZero),
    .sdaOut   (sdaOut),
    .sdaChgStb(sdaChgStb),
    .sampleStb(sampleStb)
  );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk (
  input logic clk,
  input logic rstN,
  input logic sclOut,
  input logic sclFilt,
  input logic fallStb,
  input logic sdaOut,
  input logic sdaChgStb,
  input logic sampleStb,
  input logic stretchDet
);

  a_r10_fall_marked: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOut) |-> fallStb);

  a_r10_strobe_in_low: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> !sclOut);

  a_r7_sda_moves_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (sdaOut != $past(sdaOut)) |-> $past(sdaChgStb));

  a_r8_sample_single: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |=> !sampleStb);

  a_r5_stretch_released: assert property (@(posedge clk) disable iff (!rstN)
    stretchDet |-> (sclOut && !sclFilt));

endmodule

bind i2c_scl_timing scl_timing_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclOut    (sclOut),
  .sclFilt   (sclFilt),
  .fallStb   (fallStb),
  .sdaOut    (sdaOut),
  .sdaChgStb (sdaChgStb),
  .sampleStb (sampleStb),
  .stretchDet(stretchDet)
);

// File: tb/i2c_scl_timing_tb.sv
module i2c_scl_timing_tb;

  localparam int CNT_W = 12;
  localparam int SYNC  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic [1:0] speedMode = 2'd0;
  logic [CNT_W-1:0] stdHi = 6, stdLo = 10, fastHi = 3, fastLo = 8, hsHi = 1, hsLo = 5;
  logic [7:0] spikeLen = 8'd2;
  logic [15:0] txHold = 16'd3;
  logic [7:0] rxHold = 8'd2;
  logic sclForceN = 1'b1;
  logic sdaIn = 1'b1;
  logic sdaTxBit = 1'b1;
  logic sclIn;
  logic sclOut, sdaOut, sclFilt, sdaFilt, fallStb, sdaChgStb, sampleStb, stretchDet;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  assign sclIn = sclOut & sclForceN;

  i2c_scl_timing #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .speedMode(speedMode),
    .stdHi(stdHi), .stdLo(stdLo), .fastHi(fastHi), .fastLo(fastLo),
    .hsHi(hsHi), .hsLo(hsLo), .spikeLen(spikeLen), .txHold(txHold),
    .rxHold(rxHold), .sclIn(sclIn), .sdaIn(sdaIn), .sdaTxBit(sdaTxBit),
    .sclOut(sclOut), .sdaOut(sdaOut), .sclFilt(sclFilt), .sdaFilt(sdaFilt),
    .fallStb(fallStb), .sdaChgStb(sdaChgStb), .sampleStb(sampleStb),
    .stretchDet(stretchDet)
  );

  task automatic chk(input string name, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", name, act, exp);
    end
  endtask

  task automatic wait_fall();
    bit prev;
    prev = sclOut;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (prev && !sclOut) break;
      prev = sclOut;
    end
  endtask

  task automatic go_idle();
    runEn = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  task automatic measure(input string tag, input int expLo, input int expHi);
    int lo;
    int hi;
    int seen;
    wait_fall();
    chk({tag, " R10 fall strobe"}, int'(fallStb), 1);
    lo = 0;
    while (sclOut == 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    hi = 0;
    seen = 0;
    while (sclIn == 1'b1 && hi < 5000) begin
      hi++;
      if (stretchDet) seen++;
      @(negedge clk);
    end
    chk({tag, " R3 low length"}, lo, expLo);
    chk({tag, " R4 high length"}, hi, expHi);
    chk({tag, " R5 no stretch flag"}, seen, 0);
  endtask

  task automatic t_reset();
    chk("R1 sclOut in reset", int'(sclOut), 1);
    chk("R1 sdaOut in reset", int'(sdaOut), 1);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sclFilt", int'(sclFilt), 1);
    chk("R1 sdaFilt", int'(sdaFilt), 1);
    chk("R1 strobes", int'({fallStb, sdaChgStb, sampleStb, stretchDet}), 0);
    chk("R1 sclOut", int'(sclOut), 1);
  endtask

  task automatic t_mode(input logic [1:0] m, input string tag, input int expLo, input int expHi);
    speedMode = m;
    runEn = 1'b1;
    measure(tag, expLo, expHi);
    go_idle();
  endtask

  task automatic t_stretch();
    int lo;
    int hi;
    speedMode = 2'd0;
    spikeLen = 8'd2;
    runEn = 1'b1;
    wait_fall();
    sclForceN = 1'b0;
    lo = 0;
    while (sclOut == 1'b0 && lo < 5000) begin lo++; @(negedge clk); end
    chk("R5 own low under stretch", lo, 11);
    for (int k = 0; k < 12; k++) begin
      if (k == 0) chk("R5 flag clear early", int'(stretchDet), 0);
      if (k == 11) chk("R5 flag set while held", int'(stretchDet), 1);
      if (k == 11) chk("R5 still released", int'(sclOut), 1);
      @(negedge clk);
    end
    sclForceN = 1'b1;
    hi = 1;
    @(negedge clk);
    while (sclIn == 1'b1 && hi < 5000) begin hi++; @(negedge clk); end
    chk("R5 high after stretch", hi, 6 + 2 + 7);
    go_idle();
  endtask

  task automatic t_filter();
    int lowSeen;
    runEn = 1'b0;
    spikeLen = 8'd4;
    repeat (5) @(negedge clk);
    // 4-cycle SDA pulse with length 4: dropped
    sdaIn = 1'b0;
    repeat (4) @(negedge clk);
    sdaIn = 1'b1;
    lowSeen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!sdaFilt) lowSeen++;
    end
    chk("R6 short SDA pulse ignored", lowSeen, 0);
    // 4-cycle SCL pulse: dropped, no clocking reaction
    sclForceN = 1'b0;
    repeat (4) @(negedge clk);
    sclForceN = 1'b1;
    lowSeen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!sclFilt || fallStb) lowSeen++;
    end
    chk("R6 short SCL pulse ignored", lowSeen, 0);
    // 5-cycle pulse: passes after SYNC+1+4 cycles
    sdaIn = 1'b0;
    for (int k = 1; k <= 14; k++) begin
      @(negedge clk);
      if (k == 5) sdaIn = 1'b1;
      if (k == 7) chk("R6 not yet filtered", int'(sdaFilt), 1);
      if (k == 8) chk("R6 long pulse passes", int'(sdaFilt), 0);
    end
    repeat (20) @(negedge clk);
    chk("R6 returns high", int'(sdaFilt), 1);
    // zero length: one cycle passes after SYNC+1
    spikeLen = 8'd0;
    sdaIn = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (k == 1) sdaIn = 1'b1;
      if (k == 3) chk("R6 zero length latency before", int'(sdaFilt), 1);
      if (k == 4) chk("R6 zero length single cycle", int'(sdaFilt), 0);
    end
    spikeLen = 8'd2;
    repeat (10) @(negedge clk);
  endtask

  task automatic t_txhold(input int hold, input logic bitVal);
    int pos;
    txHold = 16'(hold);
    sdaTxBit = bitVal;
    speedMode = 2'd0;
    runEn = 1'b1;
    wait_fall();
    pos = -1;
    for (int k = 0; k <= hold + 1; k++) begin
      if (sdaChgStb && pos < 0) pos = k;
      if (k == hold) chk("R7 sda held before change", int'(sdaOut), int'(!bitVal));
      if (k == hold + 1) chk("R7 sda takes new bit", int'(sdaOut), int'(bitVal));
      @(negedge clk);
    end
    chk("R7 change strobe position", pos, hold);
    go_idle();
  endtask

  task automatic t_sample();
    int pos;
    int cnt;
    rxHold = 8'd2;
    spikeLen = 8'd2;
    speedMode = 2'd0;
    runEn = 1'b1;
    wait_fall();
    while (sclOut == 1'b0) @(negedge clk);
    pos = -1;
    cnt = 0;
    for (int k = 0; k < 14; k++) begin
      if (sampleStb) begin cnt++; pos = k; end
      @(negedge clk);
    end
    chk("R8 sample strobe count", cnt, 1);
    chk("R8 sample strobe position", pos, SYNC + 2 + 2 + 2);
    go_idle();
  endtask

  task automatic t_stop();
    int lows;
    speedMode = 2'd0;
    runEn = 1'b1;
    wait_fall();
    runEn = 1'b0;
    while (sclOut == 1'b0) @(negedge clk);
    lows = 0;
    for (int k = 0; k < 60; k++) begin
      if (!sclOut || fallStb) lows++;
      @(negedge clk);
    end
    chk("R9 stays released after stop", lows, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_mode(2'd0, "R2 std", 11, 6 + 2 + 7);
    t_mode(2'd1, "R2 fast", 9, 3 + 2 + 7);
    spikeLen = 8'd0;
    t_mode(2'd2, "R2 hs", 6, 1 + 0 + 7);
    spikeLen = 8'd2;
    t_mode(2'd3, "R2 reserved", 11, 6 + 2 + 7);
    t_stretch();
    t_filter();
    t_txhold(3, 1'b0);
    t_txhold(0, 1'b1);
    t_sample();
    t_stop();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule